// File: doc/BRIEF.md
# Color LCD Controller Register Bank

This block is the software-visible register bank of a color LCD controller. It sits on a 4 KB slave window that is addressed by 32-bit word. It stores four panel timing words, the frame base addresses of the upper and lower panels, a control word and an interrupt mask. It keeps a small raw interrupt status and exposes it, both raw and masked, to software. From two of the timing words it derives the active column and row counts of the panel, and it decodes the control word into the enable, pixel-depth and ordering signals used by the display pipeline.

A vertical-blank pulse from the timing generator raises two status bits, but only while the controller is both enabled and powered. A single level interrupt follows the masked status. A read-only identification window near the top of the space returns eight bytes that depend on the variant. A palette window is decoded here and handed to an external palette store through a select, a write strobe and a word index; this block does not hold palette data.

The variant is a parameter. Variant 0 is the base layout. Variants 1 and 2 exchange the addresses of the mask and control words. Variant 2 also returns the extended identification bytes.

Top module: `lcdc_regbank`

## Requirements
- R1: After reset every stored register, the raw status, the read data, the derived geometry, `irq` and `disp_en` are zero.
- R2: Word offsets 0 to 3 hold the timing words, offset 4 the upper base and offset 5 the lower base. Word offset 11 reads back the upper base and offset 12 the lower base. Read data appears on `bus_rdata` the cycle after the read is accepted and holds until the next read.
- R3: A write to offset 0 sets `act_cols` to ((data & 0xFC) + 4) * 4. A write to offset 1 sets `act_rows` to (data & 0x3FF) + 1. Both take effect on the edge that accepts the write.
- R4: In variant 0, word offset 6 is the interrupt mask and offset 7 is the control word. In variants 1 and 2 these two offsets are exchanged, for reads and for writes alike.
- R5: `bpp_mode` is control bits [3:1]. `bgr_sel` is bit 8, `be_byte` is bit 9 and `be_pixel` is bit 10. `disp_en` is high only when control bit 0 and bit 11 are both set.
- R6: When `vblank_evt` is high on an edge while `disp_en` is high, raw status bits 2 and 3 are set. When `disp_en` is low, the pulse has no effect.
- R7: A write to offset 10 clears every raw status bit whose data bit is 1. If a vertical-blank set falls on the same edge, the set wins.
- R8: Offset 8 reads the raw status. Offset 9 reads raw status AND mask. `irq` is high exactly when that AND is nonzero.
- R9: Word offsets 0x3F8 to 0x3FF return one identification byte in bits [7:0], indexed by address bits [2:0]. Variants 0 and 1 return 10 11 04 00 0D F0 05 B1 in that order. Variant 2 returns 11 11 24 00 0D F0 05 B1.
- R10: Reads of offset 10, offsets 13 to 0x7F and offsets 0x100 to 0x3F7 return zero. Writes to them change no register.
- R11: An access to word offsets 0x80 to 0xFF drives `pal_sel` high in the same cycle. `pal_idx` carries address bits [6:0] and `pal_we` marks a write. A read of this window returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| bus_valid | input | 1 | Access strobe for one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 10 | Word address in the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| vblank_evt | input | 1 | Vertical-blank event pulse |
| irq | output | 1 | Level interrupt |
| pal_sel | output | 1 | Palette window access |
| pal_we | output | 1 | Palette window write |
| pal_idx | output | 7 | Palette word index |
| disp_en | output | 1 | Controller enabled and powered |
| bpp_mode | output | 3 | Pixel depth code |
| bgr_sel | output | 1 | Swap red and blue |
| be_byte | output | 1 | Big-endian byte order |
| be_pixel | output | 1 | Big-endian pixel order |
| act_cols | output | 11 | Derived active column count |
| act_rows | output | 11 | Derived active row count |

## Verification
A wrong stored word shows up on the next read of its offset or its alias, one cycle after the read is accepted. A wrong geometry value or control decode shows up on the geometry and control outputs on the edge right after the write. A raw status that was set or cleared wrongly, or an exchanged mask and control pair, changes `irq` on the following edge, before any software read. The bench keeps a shadow model of both a base and an extended instance on a shared bus, so an error in the address swap shows as a difference between the two.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  localparam int WADDR_W = 10;
  localparam int DATA_W  = 32;
  localparam int GEOM_W  = 11;
  localparam int NUM_TIM = 4;
  localparam int PAL_IW  = 7;

  // control word fields
  localparam int CB_EN   = 0;
  localparam int CB_BPP  = 1;
  localparam int CB_BGR  = 8;
  localparam int CB_BEB  = 9;
  localparam int CB_BEP  = 10;
  localparam int CB_PWR  = 11;

  // register word offsets
  localparam logic [3:0] OFS_UBASE = 4'd4;
  localparam logic [3:0] OFS_LBASE = 4'd5;
  localparam logic [3:0] OFS_LOW67 = 4'd6;
  localparam logic [3:0] OFS_HI67  = 4'd7;
  localparam logic [3:0] OFS_RAW   = 4'd8;
  localparam logic [3:0] OFS_MSK   = 4'd9;
  localparam logic [3:0] OFS_CLR   = 4'd10;
  localparam logic [3:0] OFS_UCUR  = 4'd11;
  localparam logic [3:0] OFS_LCUR  = 4'd12;

  function automatic logic [7:0] id_byte(input logic ext, input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0: b = ext ? 8'h11 : 8'h10;
      3'd1: b = 8'h11;
      3'd2: b = ext ? 8'h24 : 8'h04;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/lcdc_geom.sv
module lcdc_geom
  import lcdc_pkg::*;
#(
  parameter int GW = GEOM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cols_we,
  input  logic [5:0]    cols_fld,
  input  logic          rows_we,
  input  logic [9:0]    rows_fld,
  output logic [GW-1:0] cols,
  output logic [GW-1:0] rows
);
  logic [GW-1:0] cols_q, cols_n, rows_q, rows_n;

  always_comb begin
    cols_n = cols_q;
    rows_n = rows_q;
    // ((f<<2)+4)*4 == (f+1)<<4
    if (cols_we) cols_n = GW'((GW'(cols_fld) + GW'(1)) << 4);
    if (rows_we) rows_n = GW'(rows_fld) + GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cols_q <= '0;
      rows_q <= '0;
    end else begin
      cols_q <= cols_n;
      rows_q <= rows_n;
    end
  end

  assign cols = cols_q;
  assign rows = rows_q;

  // R3
  cols_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cols_q[3:0] == 4'd0);
  // R3
  rows_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rows_q <= GW'(1024));
  // R3
  cols_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cols_we |=> cols_q >= GW'(16));
endmodule

// File: rtl/lcdc_irq.sv
module lcdc_irq
  import lcdc_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vblank_evt,
  input  logic          en,
  input  logic          mask_we,
  input  logic          clr_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask,
  output logic [1:0]    raw,
  output logic          irq
);
  logic [DW-1:0] mask_q, mask_n;
  logic [1:0]    raw_q, raw_n;
  logic          set_now;

  assign set_now = vblank_evt && en;

  always_comb begin
    mask_n = mask_we ? wdata : mask_q;
    raw_n  = raw_q;
    if (clr_we)  raw_n = raw_n & ~wdata[3:2];
    if (set_now) raw_n = 2'b11;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      mask_q <= mask_n;
      raw_q  <= raw_n;
    end
  end

  assign mask = mask_q;
  assign raw  = raw_q;
  assign irq  = |(raw_q & mask_q[3:2]);

  // R6
  vb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_evt && en |=> raw_q == 2'b11);
  // R6
  vb_only_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q[0]) |-> $past(vblank_evt && en));
  // R7
  clr_nb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we && wdata[2] && !set_now |=> !raw_q[0]);
  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[3:2] == 2'b00 |-> !irq);
endmodule

// File: rtl/lcdc_idrom.sv
module lcdc_idrom
  import lcdc_pkg::*;
#(
  parameter int VARIANT = 0
) (
  input  logic [2:0] idx,
  output logic [7:0] id_b
);
  generate
    if (VARIANT == 2) begin : g_ext
      assign id_b = id_byte(1'b1, idx);
    end else begin : g_base
      assign id_b = id_byte(1'b0, idx);
    end
  endgenerate
endmodule

// File: rtl/lcdc_regbank.sv
module lcdc_regbank
  import lcdc_pkg::*;
#(
  parameter int VARIANT = 0,
  parameter int AW      = WADDR_W,
  parameter int DW      = DATA_W,
  parameter int GW      = GEOM_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_waddr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          vblank_evt,
  output logic          irq,
  output logic          pal_sel,
  output logic          pal_we,
  output logic [PAL_IW-1:0] pal_idx,
  output logic          disp_en,
  output logic [2:0]    bpp_mode,
  output logic          bgr_sel,
  output logic          be_byte,
  output logic          be_pixel,
  output logic [GW-1:0] act_cols,
  output logic [GW-1:0] act_rows
);
  localparam logic       SWAP     = (VARIANT != 0);
  localparam logic [3:0] OFS_MASK = SWAP ? OFS_HI67 : OFS_LOW67;
  localparam logic [3:0] OFS_CTRL = SWAP ? OFS_LOW67 : OFS_HI67;

  logic          rd_acc, wr_acc, in_regs, in_pal, in_id, rd_known;
  logic [3:0]    ofs;
  logic [NUM_TIM-1:0] tim_we;
  logic [DW-1:0] tim_q [NUM_TIM];
  logic [DW-1:0] ub_q, ub_n, lb_q, lb_n, ctrl_q, ctrl_n;
  logic [DW-1:0] rdata_q, rdata_n, rd_val;
  logic [DW-1:0] mask_w;
  logic [1:0]    raw_w;
  logic [7:0]    id_b;
  logic          ctrl_we;

  // address decode
  assign rd_acc  = bus_valid && !bus_write;
  assign wr_acc  = bus_valid && bus_write;
  assign in_regs = (bus_waddr >> 4) == '0;
  assign in_pal  = (bus_waddr >> PAL_IW) == AW'(1);
  assign in_id   = &bus_waddr[AW-1:3];
  assign ofs     = bus_waddr[3:0];
  assign ctrl_we = wr_acc && in_regs && (ofs == OFS_CTRL);

  assign pal_sel = bus_valid && in_pal;
  assign pal_we  = wr_acc && in_pal;
  assign pal_idx = bus_waddr[PAL_IW-1:0];

  // timing words
  generate
    for (genvar i = 0; i < NUM_TIM; i++) begin : g_tim
      assign tim_we[i] = wr_acc && in_regs && (ofs == 4'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         tim_q[i] <= '0;
        else if (tim_we[i]) tim_q[i] <= bus_wdata;
      end
    end
  endgenerate

  // base and control words
  always_comb begin
    ub_n   = ub_q;
    lb_n   = lb_q;
    ctrl_n = ctrl_q;
    if (wr_acc && in_regs && ofs == OFS_UBASE) ub_n = bus_wdata;
    if (wr_acc && in_regs && ofs == OFS_LBASE) lb_n = bus_wdata;
    if (ctrl_we) ctrl_n = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ub_q   <= '0;
      lb_q   <= '0;
      ctrl_q <= '0;
    end else begin
      ub_q   <= ub_n;
      lb_q   <= lb_n;
      ctrl_q <= ctrl_n;
    end
  end

  assign disp_en  = ctrl_q[CB_EN] && ctrl_q[CB_PWR];
  assign bpp_mode = ctrl_q[CB_BPP +: 3];
  assign bgr_sel  = ctrl_q[CB_BGR];
  assign be_byte  = ctrl_q[CB_BEB];
  assign be_pixel = ctrl_q[CB_BEP];

  lcdc_geom #(.GW(GW)) u_geom (
    .clk      (clk),
    .rst_n    (rst_n),
    .cols_we  (tim_we[0]),
    .cols_fld (bus_wdata[7:2]),
    .rows_we  (tim_we[1]),
    .rows_fld (bus_wdata[9:0]),
    .cols     (act_cols),
    .rows     (act_rows)
  );

  lcdc_irq #(.DW(DW)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .vblank_evt (vblank_evt),
    .en         (disp_en),
    .mask_we    (wr_acc && in_regs && ofs == OFS_MASK),
    .clr_we     (wr_acc && in_regs && ofs == OFS_CLR),
    .wdata      (bus_wdata),
    .mask       (mask_w),
    .raw        (raw_w),
    .irq        (irq)
  );

  lcdc_idrom #(.VARIANT(VARIANT)) u_idrom (
    .idx  (bus_waddr[2:0]),
    .id_b (id_b)
  );

  // read mux
  always_comb begin
    rd_val   = '0;
    rd_known = 1'b1;
    if (in_id) begin
      rd_val = {{(DW-8){1'b0}}, id_b};
    end else if (in_pal) begin
      rd_val = '0;
    end else if (in_regs) begin
      case (ofs)
        4'd0, 4'd1, 4'd2, 4'd3: rd_val = tim_q[ofs[1:0]];
        OFS_UBASE, OFS_UCUR:    rd_val = ub_q;
        OFS_LBASE, OFS_LCUR:    rd_val = lb_q;
        OFS_MASK:               rd_val = mask_w;
        OFS_CTRL:               rd_val = ctrl_q;
        OFS_RAW:                rd_val = {{(DW-4){1'b0}}, raw_w, 2'b00};
        OFS_MSK:                rd_val = {{(DW-4){1'b0}}, raw_w & mask_w[3:2], 2'b00};
        default:                rd_known = 1'b0;
      endcase
    end else begin
      rd_known = 1'b0;
    end
  end

  assign rdata_n = rd_acc ? rd_val : rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_n;
  end

  assign bus_rdata = rdata_q;

  // R10
  undef_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && !rd_known |=> bus_rdata == '0);
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(bus_rdata));
  // R5
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_en) |-> $past(ctrl_we));
  // R11
  pal_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc && in_pal |=> bus_rdata == '0);
endmodule

// File: tb/lcdc_regbank_bench.sv
module lcdc_regbank_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, vblank_evt = 1'b0;
  logic [9:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;

  logic [31:0] rd_b, rd_x;
  logic        irq_b, irq_x, ps_b, ps_x, pw_b, pw_x, en_b, en_x;
  logic        bgr_b, bgr_x, beb_b, beb_x, bep_b, bep_x;
  logic [6:0]  pi_b, pi_x;
  logic [2:0]  bpp_b, bpp_x;
  logic [10:0] col_b, col_x, row_b, row_x;

  int n_chk = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  lcdc_regbank #(.VARIANT(0)) u_lcdc_regbank (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(rd_b),
    .vblank_evt(vblank_evt), .irq(irq_b), .pal_sel(ps_b), .pal_we(pw_b),
    .pal_idx(pi_b), .disp_en(en_b), .bpp_mode(bpp_b), .bgr_sel(bgr_b),
    .be_byte(beb_b), .be_pixel(bep_b), .act_cols(col_b), .act_rows(row_b));

  lcdc_regbank #(.VARIANT(2)) u_lcdc_regbank_x (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(rd_x),
    .vblank_evt(vblank_evt), .irq(irq_x), .pal_sel(ps_x), .pal_we(pw_x),
    .pal_idx(pi_x), .disp_en(en_x), .bpp_mode(bpp_x), .bgr_sel(bgr_x),
    .be_byte(beb_x), .be_pixel(bep_x), .act_cols(col_x), .act_rows(row_x));

  // shadow model; index 0 = base variant, 1 = extended (swapped) variant
  logic [31:0] m_tim [4];
  logic [31:0] m_ub, m_lb;
  logic [31:0] m_ctrl [2];
  logic [31:0] m_mask [2];
  logic [1:0]  m_raw  [2];
  logic [10:0] m_cols, m_rows;

  function automatic logic [7:0] exp_id(input int v, input logic [2:0] i);
    logic [7:0] t [8];
    t = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    if (v == 1) begin t[0] = 8'h11; t[2] = 8'h24; end
    return t[i];
  endfunction

  function automatic logic m_en(input int v);
    return m_ctrl[v][0] && m_ctrl[v][11];
  endfunction

  function automatic logic [31:0] exp_rd(input int v, input logic [9:0] a);
    int mo, co;
    mo = (v == 0) ? 6 : 7;
    co = (v == 0) ? 7 : 6;
    if (a >= 10'h3F8) return {24'd0, exp_id(v, a[2:0])};
    if (a >= 10'd16) return 32'd0;
    if (a < 10'd4) return m_tim[a[1:0]];
    if (a == 10'd4 || a == 10'd11) return m_ub;
    if (a == 10'd5 || a == 10'd12) return m_lb;
    if (int'(a) == mo) return m_mask[v];
    if (int'(a) == co) return m_ctrl[v];
    if (a == 10'd8) return {28'd0, m_raw[v], 2'b00};
    if (a == 10'd9) return {28'd0, m_raw[v] & m_mask[v][3:2], 2'b00};
    return 32'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mdl(input bit wr, input logic [9:0] a, input logic [31:0] d, input bit vb);
    bit en0, en1;
    en0 = m_en(0);
    en1 = m_en(1);
    for (int v = 0; v < 2; v++) begin
      if (wr && a == 10'd10) m_raw[v] = m_raw[v] & ~d[3:2];
      if (vb && ((v == 0) ? en0 : en1)) m_raw[v] = 2'b11;
    end
    if (wr && a < 10'd16) begin
      if (a < 10'd4) m_tim[a[1:0]] = d;
      if (a == 10'd0) m_cols = 11'((({5'd0, d[7:2]}) + 11'd1) << 4);
      if (a == 10'd1) m_rows = {1'b0, d[9:0]} + 11'd1;
      if (a == 10'd4) m_ub = d;
      if (a == 10'd5) m_lb = d;
      if (a == 10'd6) begin m_mask[0] = d; m_ctrl[1] = d; end
      if (a == 10'd7) begin m_ctrl[0] = d; m_mask[1] = d; end
    end
  endtask

  task automatic check_outs();
    chk(col_b == m_cols && col_x == m_cols, "R3 cols", {21'd0, col_b}, {21'd0, m_cols});
    chk(row_b == m_rows && row_x == m_rows, "R3 rows", {21'd0, row_b}, {21'd0, m_rows});
    chk(en_b == m_en(0) && en_x == m_en(1), "R5 disp_en", {30'd0, en_x, en_b}, {30'd0, m_en(1), m_en(0)});
    chk(bpp_b == m_ctrl[0][3:1] && bpp_x == m_ctrl[1][3:1], "R5 bpp", {29'd0, bpp_b}, {29'd0, m_ctrl[0][3:1]});
    chk({bgr_b, beb_b, bep_b} == {m_ctrl[0][8], m_ctrl[0][9], m_ctrl[0][10]} &&
        {bgr_x, beb_x, bep_x} == {m_ctrl[1][8], m_ctrl[1][9], m_ctrl[1][10]},
        "R5 order bits", {29'd0, bgr_b, beb_b, bep_b}, {29'd0, m_ctrl[0][8], m_ctrl[0][9], m_ctrl[0][10]});
    chk(irq_b == |(m_raw[0] & m_mask[0][3:2]) && irq_x == |(m_raw[1] & m_mask[1][3:2]),
        "R8 irq", {30'd0, irq_x, irq_b}, {30'd0, |(m_raw[1] & m_mask[1][3:2]), |(m_raw[0] & m_mask[0][3:2])});
  endtask

  // one bus cycle: inputs at a falling edge, results sampled at the next falling edge
  task automatic op(input bit acc, input bit wr, input logic [9:0] a, input logic [31:0] d, input bit vb);
    logic [31:0] e0, e1;
    bus_valid = acc; bus_write = wr; bus_waddr = a; bus_wdata = d; vblank_evt = vb;
    e0 = exp_rd(0, a);
    e1 = exp_rd(1, a);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; vblank_evt = 1'b0;
    mdl(acc && wr, a, d, vb);
    if (acc && !wr) begin
      chk(rd_b == e0, "R2/R4/R8/R9/R10 read base", rd_b, e0);
      chk(rd_x == e1, "R2/R4/R8/R9/R10 read ext", rd_x, e1);
    end
    check_outs();
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d); op(1, 1, a, d, 0); endtask
  task automatic rd(input logic [9:0] a);                      op(1, 0, a, 0, 0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1CDC_0C0F));
    for (int i = 0; i < 4; i++) m_tim[i] = '0;
    m_ub = '0; m_lb = '0; m_cols = '0; m_rows = '0;
    for (int v = 0; v < 2; v++) begin m_ctrl[v] = '0; m_mask[v] = '0; m_raw[v] = '0; end

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_b == 0 && rd_x == 0, "R1 rdata", rd_b, 0);
    chk(irq_b == 0 && irq_x == 0 && en_b == 0 && en_x == 0, "R1 irq/en", {30'd0, irq_b, en_b}, 0);
    chk(col_b == 0 && row_b == 0, "R1 geometry", {21'd0, col_b}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 13; a++) rd(10'(a));

    // R3 geometry corners
    wr(0, 32'h0);          chk(col_b == 11'd16, "R3 cols min", {21'd0, col_b}, 16);
    wr(0, 32'hFFFF_FFFF);  chk(col_b == 11'd1024, "R3 cols max", {21'd0, col_b}, 1024);
    wr(0, 32'h0000_004F);  chk(col_b == 11'd320, "R3 cols 320", {21'd0, col_b}, 320);
    wr(1, 32'h0);          chk(row_b == 11'd1, "R3 rows min", {21'd0, row_b}, 1);
    wr(1, 32'hFFFF_FFFF);  chk(row_b == 11'd1024, "R3 rows max", {21'd0, row_b}, 1024);

    // R2 bases and aliases
    wr(4, 32'hA5A5_1000); wr(5, 32'h5A5A_2000);
    rd(4); rd(11); rd(5); rd(12);

    // R4 / R6: base is enabled only by offset 7, ext only by offset 6
    wr(7, 32'h0000_0801); // base ctrl: en+pwr; ext mask
    chk(en_b == 1 && en_x == 0, "R4 swap ctrl", {30'd0, en_x, en_b}, 32'h1);
    op(0, 0, 0, 0, 1);    // vblank: base only
    rd(8);
    chk(irq_b == 0, "R8 irq masked off", {31'd0, irq_b}, 0);
    wr(6, 32'h0000_000C); // base mask; ext ctrl (not powered)
    chk(irq_b == 1 && en_x == 0, "R8 irq on mask", {30'd0, en_x, irq_b}, 32'h1);
    rd(9);
    wr(6, 32'h0000_0001); // R6 enable bit alone does not enable
    op(0, 0, 0, 0, 1);
    rd(8);
    wr(6, 32'h0000_080D); wr(7, 32'h0000_080D);
    op(0, 0, 0, 0, 1);
    rd(8); rd(9);
    // R7 clear, then same-edge clear with vblank
    wr(10, 32'h0000_0004); rd(8);
    op(1, 1, 10'd10, 32'h0000_000C, 1);
    chk(irq_b == 1 && irq_x == 1, "R7 set wins", {30'd0, irq_x, irq_b}, 32'h3);
    wr(10, 32'hFFFF_FFFF); rd(8);

    // R10 writes to undefined offsets are ignored
    wr(13, 32'hDEAD_BEEF); wr(10'h40, 32'hDEAD_BEEF); wr(10'h200, 32'hDEAD_BEEF); rd(10);
    for (int a = 0; a < 13; a++) rd(10'(a));
    rd(10'h3F7);

    // R9 id window
    for (int a = 10'h3F8; a <= 10'h3FF; a++) rd(10'(a));

    // R11 palette window
    bus_valid = 1; bus_write = 1; bus_waddr = 10'h0C5; bus_wdata = 32'h1234;
    #1;
    chk(ps_b && pw_b && pi_b == 7'h45 && ps_x, "R11 palette write select", {24'd0, ps_b, pi_b}, {24'd0, 8'hC5});
    bus_write = 0; bus_waddr = 10'h07F;
    #1;
    chk(!ps_b && !pw_b, "R11 outside window", {31'd0, ps_b}, 0);
    @(negedge clk);
    bus_valid = 0;
    rd(10'h080); rd(10'h0FF);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int k;
      logic [9:0]  a;
      logic [31:0] d;
      k = int'($urandom % 10);
      d = $urandom;
      if (k < 7) a = 10'($urandom % 16);
      else if (k == 7) a = 10'h3F8 + 10'($urandom % 8);
      else if (k == 8) a = 10'h080 + 10'($urandom % 128);
      else a = 10'($urandom % 1024);
      if (a == 10'd6 || a == 10'd7) d = d & 32'h0000_0F0F | (($urandom % 2) != 0 ? 32'h0000_0801 : 32'h0);
      op(($urandom % 4) != 0, ($urandom % 2) != 0, a, d, ($urandom % 3) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule